// File: doc/BRIEF.md
# Command and Response Buffer Engine

This block sequences one command through a host interface of a security coprocessor. The host fills a shared byte buffer through a data port that takes 1 to 4 bytes per access. The block finds out when the command is complete by reading the length field in the command header. A go request then passes the command to an execution backend. The backend writes its response into the same buffer and signals done. The host then drains the response through the data port. The block keeps a status word up to date: flag bits, a burst count and fixed family bits. It emits one-cycle event pulses that an interrupt unit, outside this block, can latch.

The sequencer has five states. Idle (code 0) is left only by a command-ready request, which leads to Ready (1). The first data write in Ready leads to Reception (2). Go in Reception leads to Execution (3). Backend done leads to Completion (4). Command-ready leads from Completion back to Ready. Command-ready in Reception aborts at once back to Ready. Command-ready in Execution requests a cancel, and the abort ends in Ready when the backend reports done. Response-retry stays in Completion and rewinds the read position.

Top module: `cmdrsp_engine`

## Requirements
- R1: After reset the state is Idle (code 0). The status word then holds only the family bits (27:26) and a burst count (bits 23:8) equal to the buffer capacity. The valid flag (bit 7), command-ready (bit 6), data-available (bit 4), expect (bit 3) and self-test-done (bit 2) are all clear.
- R2: A status write whose operation is command-ready (sts_op bit 2) while Idle moves to Ready. It sets only command-ready, and it pulses irq_cmd_ready on the next cycle.
- R3: The first data write in Ready moves to Reception, sets expect and valid, and stores the bytes, least significant lane first. Data writes in Idle, Execution or Completion change nothing.
- R4: Once more than 5 bytes are buffered with expect set, the command length is the big-endian 32-bit value in buffer bytes 2 to 5. Expect stays set while that length exceeds the bytes received; otherwise it clears and valid stays set.
- R5: Bytes that would land beyond the buffer capacity are discarded, and the overflow clears expect while keeping valid.
- R6: Go (sts_op bit 1) acts only in Reception with expect clear. It moves to Execution and pulses be_req for one cycle, with be_len equal to the received byte count. In every other case it has no effect.
- R7: Backend done in Execution, with no abort pending, moves to Completion. It rewinds the position, sets valid and data-available, and pulses irq_data_avail and irq_sts_valid.
- R8: In Completion with data-available set, each read lane returns the next response byte. The response length is the header length capped at the capacity. After the last byte, data-available clears, valid stays set and irq_sts_valid pulses. Every other read lane returns 0xFF.
- R9: The burst count is the number of response bytes remaining while data-available is set, and otherwise the free buffer space. It is capped at 0xFF when sts_byte is high.
- R10: Response-retry (sts_op bit 0) in Completion rewinds the read position and sets valid and data-available again. In other states it has no effect.
- R11: Command-ready has a different effect in each state. In Ready it only rewinds the position. In Completion it returns to Ready with only command-ready set and pulses irq_cmd_ready. In Reception it aborts at once to Ready with command-ready set. In Execution it pulses be_cancel once, and the following done returns to Ready with command-ready set and irq_cmd_ready pulsed.
- R12: A status write with more than one operation bit set is ignored. Every status update preserves the self-test-done flag, which is set by done with be_selftest high and stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sts_wr | input | 1 | Status operation strobe |
| sts_op | input | 3 | {command-ready, go, response-retry} |
| sts_byte | input | 1 | Status read is byte wide (caps burst count) |
| fifo_wr | input | 1 | Data write strobe |
| fifo_wdata | input | 32 | Write bytes, lane 0 in bits 7:0 |
| fifo_wsize | input | 3 | Bytes in the write, 1 to 4 |
| fifo_rd | input | 1 | Data read strobe |
| fifo_rsize | input | 3 | Bytes in the read, 1 to 4 |
| fifo_rdata | output | 32 | Read bytes, valid in the cycle of fifo_rd |
| status_word | output | 32 | Flags, burst count, family bits |
| state_o | output | 3 | Current state code |
| irq_cmd_ready | output | 1 | Command-ready event pulse |
| irq_sts_valid | output | 1 | Status-valid event pulse |
| irq_data_avail | output | 1 | Data-available event pulse |
| be_req | output | 1 | Request pulse to the backend |
| be_len | output | OW | Command byte count for the request |
| be_cancel | output | 1 | Cancel request pulse to the backend |
| be_done | input | 1 | Backend completion pulse |
| be_selftest | input | 1 | Self-test finished, sampled with be_done |
| be_wr | input | 1 | Backend response byte write |
| be_waddr | input | AW | Response byte address |
| be_wdata | input | 8 | Response byte |

## Verification
Assertions check on every cycle that expect appears only in Reception and data-available only in Completion. They also check that the buffer position never passes the capacity, that a backend request is issued only from Execution, and that self-test-done never falls. The length decode across split header writes, the overflow discard, the burst count in both access widths, and the abort paths all involve the contents of the data stream. The bench shows these in its scenarios, comparing every cycle against a behavioural model.

// File: rtl/cmdrsp_pkg.sv
package cmdrsp_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_READY = 3'd1,
        ST_RECV  = 3'd2,
        ST_EXEC  = 3'd3,
        ST_DONE  = 3'd4
    } cr_state_e;

    localparam logic [7:0] NO_DATA_BYTE = 8'hFF;
    localparam int         HDR_FIRST    = 2;
    localparam int         HDR_LAST     = 5;
    localparam int         LANES        = 4;
endpackage

// File: rtl/cmdrsp_buffer.sv
module cmdrsp_buffer #(
    parameter int DEPTH = 256,
    parameter int OW    = $clog2(DEPTH + 1),
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic [3:0]    lane_we,
    input  logic [OW-1:0] base,
    input  logic [31:0]   lane_wdata,
    input  logic          be_we,
    input  logic [AW-1:0] be_addr,
    input  logic [7:0]    be_wdata,
    output logic [31:0]   rd_bytes
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        for (int k = 0; k < 4; k++) begin
            if (lane_we[k]) mem[AW'(base + OW'(k))] <= lane_wdata[8*k +: 8];
        end
        if (be_we) mem[be_addr] <= be_wdata;
    end

    for (genvar g = 0; g < 4; g++) begin : g_rd
        assign rd_bytes[8*g +: 8] = mem[AW'(base + OW'(g))];
    end
endmodule

// File: rtl/cmdrsp_burst.sv
module cmdrsp_burst #(
    parameter int DEPTH = 256,
    parameter int OW    = $clog2(DEPTH + 1)
) (
    input  logic          dav,
    input  logic [OW-1:0] off,
    input  logic [OW-1:0] rlen,
    input  logic          byte_acc,
    output logic [15:0]   burst
);
    int unsigned rem;

    always_comb begin
        if (dav) rem = (rlen > off) ? 32'(rlen) - 32'(off) : 32'd0;
        else     rem = 32'(DEPTH) - 32'(off);
        if (byte_acc && rem > 32'd255) rem = 32'd255;
        burst = rem[15:0];
    end
endmodule

// File: rtl/cmdrsp_fsm.sv
module cmdrsp_fsm
    import cmdrsp_pkg::*;
#(
    parameter int DEPTH = 256,
    parameter int OW    = $clog2(DEPTH + 1),
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sts_wr,
    input  logic [2:0]    sts_op,
    input  logic          fifo_wr,
    input  logic [31:0]   fifo_wdata,
    input  logic [2:0]    fifo_wsize,
    input  logic          fifo_rd,
    input  logic [2:0]    fifo_rsize,
    input  logic          be_done,
    input  logic          be_selftest,
    input  logic          be_wr,
    input  logic [AW-1:0] be_waddr,
    input  logic [7:0]    be_wdata,
    output cr_state_e     state,
    output logic [OW-1:0] off,
    output logic [OW-1:0] rlen,
    output logic          f_valid,
    output logic          f_cmdrdy,
    output logic          f_dav,
    output logic          f_expect,
    output logic          f_selftest,
    output logic [3:0]    lane_we,
    output logic [3:0]    rd_mask,
    output logic          be_we,
    output logic          irq_cr,
    output logic          irq_sv,
    output logic          irq_dav,
    output logic          be_req,
    output logic [OW-1:0] be_len,
    output logic          be_cancel
);
    localparam logic [2:0] OP_CR    = 3'b100;
    localparam logic [2:0] OP_GO    = 3'b010;
    localparam logic [2:0] OP_RETRY = 3'b001;

    cr_state_e     st_q, st_d;
    logic [OW-1:0] off_q, off_d, len_q, len_d;
    logic [31:0]   hdr_q, hdr_d;
    logic          v_q, v_d, cr_q, cr_d, dav_q, dav_d, exp_q, exp_d, stf_q, stf_d;
    logic          ab_q, ab_d;
    logic          irq_cr_d, irq_sv_d, irq_dav_d, req_d, cancel_d;
    logic          irq_cr_q, irq_sv_q, irq_dav_q, req_q, cancel_q;

    logic [2:0] wsz, rsz;
    assign wsz = (fifo_wsize > 3'd4) ? 3'd4 : fifo_wsize;
    assign rsz = (fifo_rsize > 3'd4) ? 3'd4 : fifo_rsize;

    assign rlen  = (hdr_q >= 32'(DEPTH)) ? OW'(DEPTH) : OW'(hdr_q);
    assign be_we = be_wr && (st_q == ST_EXEC);

    // next-state and status-flag logic
    always_comb begin
        int unsigned pos;
        int unsigned cnt;
        logic        ovf, e0, v0;
        logic [OW-1:0] nxt;
        st_d = st_q;   off_d = off_q; len_d = len_q; hdr_d = hdr_q;
        v_d  = v_q;    cr_d = cr_q;   dav_d = dav_q; exp_d = exp_q;
        stf_d = stf_q; ab_d = ab_q;
        irq_cr_d = 1'b0; irq_sv_d = 1'b0; irq_dav_d = 1'b0;
        req_d = 1'b0; cancel_d = 1'b0;
        lane_we = '0; rd_mask = '0;
        cnt = 0; ovf = 1'b0; e0 = 1'b0; v0 = 1'b0; pos = 0; nxt = '0;

        if (be_we) begin
            pos = 32'(be_waddr);
            if (pos >= HDR_FIRST && pos <= HDR_LAST) hdr_d[8*(HDR_LAST-pos) +: 8] = be_wdata;
        end

        if (st_q == ST_EXEC && be_done) begin
            if (be_selftest) stf_d = 1'b1;
            off_d = '0;
            if (ab_q) begin
                st_d = ST_READY; ab_d = 1'b0;
                {v_d, cr_d, dav_d, exp_d} = 4'b0100;
                irq_cr_d = 1'b1;
            end else begin
                st_d = ST_DONE;
                {v_d, cr_d, dav_d, exp_d} = 4'b1010;
                irq_dav_d = 1'b1; irq_sv_d = 1'b1;
            end
        end else if (sts_wr) begin
            if (sts_op == OP_CR) begin
                unique case (st_q)
                    ST_IDLE: begin
                        st_d = ST_READY;
                        {v_d, cr_d, dav_d, exp_d} = 4'b0100;
                        irq_cr_d = 1'b1;
                    end
                    ST_READY: off_d = '0;
                    ST_RECV: begin
                        st_d = ST_READY; off_d = '0;
                        {v_d, cr_d, dav_d, exp_d} = 4'b0100;
                        irq_cr_d = 1'b1;
                    end
                    ST_EXEC: begin
                        ab_d = 1'b1;
                        cancel_d = !ab_q;
                    end
                    ST_DONE: begin
                        st_d = ST_READY; off_d = '0;
                        if (!cr_q) begin
                            {v_d, cr_d, exp_d} = 3'b010;
                            irq_cr_d = 1'b1;
                        end
                        dav_d = 1'b0;
                    end
                    default: ;
                endcase
            end else if (sts_op == OP_GO) begin
                if (st_q == ST_RECV && !exp_q) begin
                    st_d = ST_EXEC; req_d = 1'b1; len_d = off_q;
                end
            end else if (sts_op == OP_RETRY) begin
                if (st_q == ST_DONE) begin
                    off_d = '0;
                    {v_d, cr_d, dav_d, exp_d} = 4'b1010;
                end
            end
        end else if (fifo_wr && wsz != 3'd0) begin
            if (st_q == ST_READY || st_q == ST_RECV) begin
                if (st_q == ST_READY) begin
                    st_d = ST_RECV;
                    {v_d, cr_d, dav_d, exp_d} = 4'b1001;
                end
                e0 = (st_q == ST_READY) ? 1'b1 : exp_q;
                v0 = (st_q == ST_READY) ? 1'b1 : v_q;
                if (e0) begin
                    for (int k = 0; k < 4; k++) begin
                        if (k < int'(wsz)) begin
                            pos = 32'(off_q) + 32'(k);
                            if (pos < 32'(DEPTH)) begin
                                lane_we[k] = 1'b1;
                                cnt = cnt + 1;
                                if (pos >= HDR_FIRST && pos <= HDR_LAST)
                                    hdr_d[8*(HDR_LAST-pos) +: 8] = fifo_wdata[8*k +: 8];
                            end else begin
                                ovf = 1'b1;
                            end
                        end
                    end
                    nxt   = off_q + OW'(cnt);
                    off_d = nxt;
                    if (ovf) begin
                        {v_d, cr_d, dav_d, exp_d} = 4'b1000;
                    end else if (32'(nxt) > HDR_LAST) begin
                        if (hdr_d > 32'(nxt)) {v_d, cr_d, dav_d, exp_d} = 4'b1001;
                        else                  {v_d, cr_d, dav_d, exp_d} = 4'b1000;
                        if (!v0) irq_sv_d = 1'b1;
                    end
                end
            end
        end else if (fifo_rd && rsz != 3'd0) begin
            if (st_q == ST_DONE && dav_q) begin
                for (int k = 0; k < 4; k++) begin
                    if (k < int'(rsz) && (k == 0 || 32'(off_q) + 32'(k) < 32'(rlen))) begin
                        rd_mask[k] = 1'b1;
                        cnt = cnt + 1;
                    end
                end
                nxt   = off_q + OW'(cnt);
                off_d = nxt;
                if (nxt >= rlen) begin
                    {v_d, cr_d, dav_d, exp_d} = 4'b1000;
                    irq_sv_d = 1'b1;
                end
            end
        end
    end

    // state and output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_IDLE; off_q <= '0; len_q <= '0; hdr_q <= '0;
            v_q <= 1'b0; cr_q <= 1'b0; dav_q <= 1'b0; exp_q <= 1'b0; stf_q <= 1'b0;
            ab_q <= 1'b0;
            irq_cr_q <= 1'b0; irq_sv_q <= 1'b0; irq_dav_q <= 1'b0;
            req_q <= 1'b0; cancel_q <= 1'b0;
        end else begin
            st_q <= st_d; off_q <= off_d; len_q <= len_d; hdr_q <= hdr_d;
            v_q <= v_d; cr_q <= cr_d; dav_q <= dav_d; exp_q <= exp_d; stf_q <= stf_d;
            ab_q <= ab_d;
            irq_cr_q <= irq_cr_d; irq_sv_q <= irq_sv_d; irq_dav_q <= irq_dav_d;
            req_q <= req_d; cancel_q <= cancel_d;
        end
    end

    assign state = st_q;     assign off = off_q;
    assign f_valid = v_q;    assign f_cmdrdy = cr_q;  assign f_dav = dav_q;
    assign f_expect = exp_q; assign f_selftest = stf_q;
    assign irq_cr = irq_cr_q; assign irq_sv = irq_sv_q; assign irq_dav = irq_dav_q;
    assign be_req = req_q;   assign be_len = len_q;   assign be_cancel = cancel_q;

    assert_idle_clean_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE) |-> !(v_q || cr_q || dav_q || exp_q));
    assert_expect_in_rx_R4: assert property (@(posedge clk) disable iff (!rst_n)
        exp_q |-> (st_q == ST_RECV));
    assert_off_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        off_q <= OW'(DEPTH));
    assert_req_from_exec_R6: assert property (@(posedge clk) disable iff (!rst_n)
        req_q |-> (st_q == ST_EXEC));
    assert_dav_in_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        dav_q |-> (st_q == ST_DONE));
    assert_selftest_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
        stf_q |=> stf_q);
endmodule

// File: rtl/cmdrsp_engine.sv
module cmdrsp_engine
    import cmdrsp_pkg::*;
#(
    parameter int         BUF_BYTES = 256,
    parameter logic [1:0] FAMILY    = 2'b10,
    localparam int        OW        = $clog2(BUF_BYTES + 1),
    localparam int        AW        = $clog2(BUF_BYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sts_wr,
    input  logic [2:0]    sts_op,
    input  logic          sts_byte,
    input  logic          fifo_wr,
    input  logic [31:0]   fifo_wdata,
    input  logic [2:0]    fifo_wsize,
    input  logic          fifo_rd,
    input  logic [2:0]    fifo_rsize,
    output logic [31:0]   fifo_rdata,
    output logic [31:0]   status_word,
    output logic [2:0]    state_o,
    output logic          irq_cmd_ready,
    output logic          irq_sts_valid,
    output logic          irq_data_avail,
    output logic          be_req,
    output logic [OW-1:0] be_len,
    output logic          be_cancel,
    input  logic          be_done,
    input  logic          be_selftest,
    input  logic          be_wr,
    input  logic [AW-1:0] be_waddr,
    input  logic [7:0]    be_wdata
);
    cr_state_e     state;
    logic [OW-1:0] off, rlen;
    logic          f_valid, f_cmdrdy, f_dav, f_expect, f_selftest, be_we;
    logic [3:0]    lane_we, rd_mask;
    logic [31:0]   rd_bytes;
    logic [15:0]   burst;

    cmdrsp_fsm #(.DEPTH(BUF_BYTES), .OW(OW), .AW(AW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .sts_wr(sts_wr), .sts_op(sts_op),
        .fifo_wr(fifo_wr), .fifo_wdata(fifo_wdata), .fifo_wsize(fifo_wsize),
        .fifo_rd(fifo_rd), .fifo_rsize(fifo_rsize), .be_done(be_done),
        .be_selftest(be_selftest), .be_wr(be_wr), .be_waddr(be_waddr), .be_wdata(be_wdata),
        .state(state), .off(off), .rlen(rlen), .f_valid(f_valid), .f_cmdrdy(f_cmdrdy),
        .f_dav(f_dav), .f_expect(f_expect), .f_selftest(f_selftest),
        .lane_we(lane_we), .rd_mask(rd_mask), .be_we(be_we),
        .irq_cr(irq_cmd_ready), .irq_sv(irq_sts_valid), .irq_dav(irq_data_avail),
        .be_req(be_req), .be_len(be_len), .be_cancel(be_cancel)
    );

    cmdrsp_buffer #(.DEPTH(BUF_BYTES), .OW(OW), .AW(AW)) u_buf (
        .clk(clk), .lane_we(lane_we), .base(off), .lane_wdata(fifo_wdata),
        .be_we(be_we), .be_addr(be_waddr), .be_wdata(be_wdata), .rd_bytes(rd_bytes)
    );

    cmdrsp_burst #(.DEPTH(BUF_BYTES), .OW(OW)) u_burst (
        .dav(f_dav), .off(off), .rlen(rlen), .byte_acc(sts_byte), .burst(burst)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign fifo_rdata[8*g +: 8] = rd_mask[g] ? rd_bytes[8*g +: 8] : NO_DATA_BYTE;
    end

    assign status_word = {4'b0, FAMILY, 2'b0, burst, f_valid, f_cmdrdy, 1'b0,
                          f_dav, f_expect, f_selftest, 2'b0};
    assign state_o = state;
endmodule

// File: tb/cmdrsp_engine_tb.sv
module cmdrsp_engine_tb;
    localparam int         CLK_PERIOD = 10;
    localparam int         CAP = 256;
    localparam logic [1:0] FAM = 2'b10;

    logic clk = 1'b0, rst_n = 1'b0;
    logic sts_wr = 0, sts_byte = 0, fifo_wr = 0, fifo_rd = 0;
    logic [2:0] sts_op = 0, fifo_wsize = 0, fifo_rsize = 0;
    logic [31:0] fifo_wdata = 0;
    logic be_done = 0, be_selftest = 0, be_wr = 0;
    logic [7:0] be_waddr = 0, be_wdata = 0;
    logic [31:0] fifo_rdata, status_word;
    logic [2:0] state_o;
    logic irq_cmd_ready, irq_sts_valid, irq_data_avail, be_req, be_cancel;
    logic [8:0] be_len;

    cmdrsp_engine #(.BUF_BYTES(CAP), .FAMILY(FAM)) u_dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0, errors = 0;
    string cur_req = "R1";

    // behavioural reference model
    int m_state = 0, m_off = 0, m_len = 0;
    bit m_v, m_cr, m_dav, m_exp, m_st, m_ab;
    bit m_icr, m_isv, m_idav, m_req, m_cancel;
    byte unsigned m_buf [CAP];

    function automatic int hdr_len();
        return {m_buf[2], m_buf[3], m_buf[4], m_buf[5]};
    endfunction
    function automatic int resp_len();
        int h = hdr_len();
        return (h < 0 || h > CAP) ? CAP : h;
    endfunction
    function automatic logic [31:0] exp_status();
        int b = m_dav ? resp_len() - m_off : CAP - m_off;
        if (sts_byte && b > 255) b = 255;
        return {4'b0, FAM, 2'b0, b[15:0], m_v, m_cr, 1'b0, m_dav, m_exp, m_st, 2'b0};
    endfunction
    function automatic logic [31:0] exp_read();
        logic [31:0] r = 32'hFFFF_FFFF;
        for (int k = 0; k < int'(fifo_rsize); k++)
            if (m_state == 4 && m_dav && (k == 0 || m_off + k < resp_len()))
                r[8*k +: 8] = m_buf[m_off + k];
        return r;
    endfunction

    task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", cur_req, what, act, exp);
        end
    endtask

    task automatic model_apply();
        int n;
        m_icr = 0; m_isv = 0; m_idav = 0; m_req = 0; m_cancel = 0;
        if (be_wr && m_state == 3) m_buf[be_waddr] = be_wdata;
        if (m_state == 3 && be_done) begin
            if (be_selftest) m_st = 1;
            m_off = 0;
            if (m_ab) begin
                m_ab = 0; m_state = 1; {m_v, m_cr, m_dav, m_exp} = 4'b0100; m_icr = 1;
            end else begin
                m_state = 4; {m_v, m_cr, m_dav, m_exp} = 4'b1010; m_idav = 1; m_isv = 1;
            end
        end else if (sts_wr) begin
            if (sts_op == 3'b100) begin
                case (m_state)
                    0, 2: begin m_state = 1; m_off = 0; {m_v, m_cr, m_dav, m_exp} = 4'b0100; m_icr = 1; end
                    1: m_off = 0;
                    3: begin m_cancel = !m_ab; m_ab = 1; end
                    4: begin m_state = 1; m_off = 0; {m_v, m_cr, m_dav, m_exp} = 4'b0100; m_icr = 1; end
                    default: ;
                endcase
            end else if (sts_op == 3'b010 && m_state == 2 && !m_exp) begin
                m_state = 3; m_req = 1; m_len = m_off;
            end else if (sts_op == 3'b001 && m_state == 4) begin
                m_off = 0; {m_v, m_cr, m_dav, m_exp} = 4'b1010;
            end
        end else if (fifo_wr && (m_state == 1 || m_state == 2)) begin
            bit ovf = 0;
            if (m_state == 1) begin m_state = 2; {m_v, m_cr, m_dav, m_exp} = 4'b1001; end
            if (m_exp) begin
                for (int k = 0; k < int'(fifo_wsize); k++) begin
                    if (m_off < CAP) begin m_buf[m_off] = fifo_wdata[8*k +: 8]; m_off++; end
                    else ovf = 1;
                end
                if (ovf) {m_v, m_cr, m_dav, m_exp} = 4'b1000;
                else if (m_off > 5) m_exp = (hdr_len() > m_off || hdr_len() < 0);
            end
        end else if (fifo_rd && m_state == 4 && m_dav) begin
            n = 0;
            for (int k = 0; k < int'(fifo_rsize); k++)
                if (k == 0 || m_off + k < resp_len()) n++;
            m_off += n;
            if (m_off >= resp_len()) begin {m_v, m_cr, m_dav, m_exp} = 4'b1000; m_isv = 1; end
        end
    endtask

    // one clock: compare all outputs with the model, then advance both
    task automatic step();
        @(negedge clk); #1;
        chk("state", 32'(state_o), 32'(m_state));
        chk("status", status_word, exp_status());
        chk("irqs", {29'b0, irq_cmd_ready, irq_sts_valid, irq_data_avail}, {29'b0, m_icr, m_isv, m_idav});
        chk("be_req/cancel", {30'b0, be_req, be_cancel}, {30'b0, m_req, m_cancel});
        if (m_req) chk("be_len", 32'(be_len), 32'(m_len));
        if (fifo_rd) chk("rdata", fifo_rdata, exp_read());
        @(posedge clk); #1;
        model_apply();
        sts_wr = 0; fifo_wr = 0; fifo_rd = 0; be_done = 0; be_wr = 0; be_selftest = 0;
    endtask

    task automatic t_sts(input logic [2:0] op); sts_wr = 1; sts_op = op; step(); endtask
    task automatic t_wr(input logic [31:0] d, input int sz);
        fifo_wr = 1; fifo_wdata = d; fifo_wsize = 3'(sz); step();
    endtask
    task automatic t_rd(input int sz); fifo_rd = 1; fifo_rsize = 3'(sz); step(); endtask
    task automatic t_idle(); step(); endtask
    task automatic t_bew(input int a, input int d);
        be_wr = 1; be_waddr = 8'(a); be_wdata = 8'(d); step();
    endtask
    task automatic t_done(input bit s); be_done = 1; be_selftest = s; step(); endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < CAP; i++) m_buf[i] = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        cur_req = "R1"; t_idle();
        chk("reset status R1", status_word, {4'b0, FAM, 2'b0, 16'd256, 8'h00});
        cur_req = "R8"; t_rd(4);                         // R8 filler in idle
        cur_req = "R3"; t_wr(32'h1234_5678, 4); t_idle(); // R3 dropped in idle
        cur_req = "R2"; t_sts(3'b100); t_idle();          // R2 idle -> ready
        cur_req = "R9"; sts_byte = 1; t_idle();           // R9 byte cap 0xFF
        chk("burst byte R9", 32'(status_word[23:8]), 32'd255);
        sts_byte = 0; t_idle();
        cur_req = "R6"; t_sts(3'b010);                    // R6 go in ready ignored
        cur_req = "R3"; t_wr(32'h0000_01C1, 4); t_idle(); // R3 ready -> reception
        cur_req = "R4"; t_wr(32'h0000_0A00, 2); t_idle(); // R4 6 bytes, length 10
        chk("expect kept R4", 32'(status_word[3]), 32'd1);
        cur_req = "R6"; t_sts(3'b010);                    // R6 go with expect set ignored
        cur_req = "R12"; t_sts(3'b011);                   // R12 two op bits ignored
        cur_req = "R4"; t_wr(32'h00CC_BBAA, 3); t_wr(32'h0000_00DD, 1); t_idle();
        chk("expect cleared R4", 32'(status_word[3]), 32'd0);
        cur_req = "R6"; t_sts(3'b010); t_idle();          // R6 request, length 10
        cur_req = "R3"; t_wr(32'hFFFF_FFFF, 4);            // R3 dropped in execution
        cur_req = "R7";
        t_bew(0, 8'h80); t_bew(1, 8'h02); t_bew(2, 0); t_bew(3, 0); t_bew(4, 0); t_bew(5, 8);
        t_bew(6, 8'h5A); t_bew(7, 8'hA5);
        t_done(1); t_idle();                               // R7 completion
        cur_req = "R12"; chk("selftest set R12", 32'(status_word[2]), 32'd1);
        cur_req = "R9"; chk("burst remaining R9", 32'(status_word[23:8]), 32'd8);
        cur_req = "R3"; t_wr(32'h1111_1111, 4);            // R3 dropped in completion
        cur_req = "R8"; t_rd(4); t_rd(3); t_rd(4); t_idle(); t_rd(2);
        chk("dav cleared R8", 32'(status_word[4]), 32'd0);
        cur_req = "R10"; t_sts(3'b001); t_idle(); t_rd(2); // R10 retry
        cur_req = "R11"; t_sts(3'b100); t_idle();          // R11 completion -> ready
        t_sts(3'b100);                                     // R11 ready rewind
        t_wr(32'h0302_0100, 4); t_sts(3'b100); t_idle();   // R11 abort in reception
        cur_req = "R5";                                    // R5 overflow
        t_wr(32'h0000_00C1, 4); t_wr(32'h0000_0010, 4);
        for (int i = 2; i < 64; i++) t_wr(32'(i), 4);
        chk("full burst R5", 32'(status_word[23:8]), 32'd0);
        t_wr(32'hDEAD_BEEF, 4); t_idle();
        chk("expect after overflow R5", 32'(status_word[3]), 32'd0);
        cur_req = "R6"; t_sts(3'b010); t_idle();          // R6 request, length 256
        cur_req = "R11"; t_sts(3'b100); t_sts(3'b100); t_idle();
        t_done(0); t_idle();                               // R11 abort ends in ready
        cur_req = "R12"; chk("selftest kept R12", 32'(status_word[2]), 32'd1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule